// File: doc/BRIEF.md
# Paged Command Decoder for a Graphic LCD Controller

This block takes byte-wide traffic for a small graphic LCD controller and turns it into register updates and display-RAM write strobes. Each byte arrives with a one-cycle strobe and a data/command select bit. Command bytes are decoded through a two-bit command page register. The same opcode therefore means different things depending on which page is selected. A few opcodes work the same way on every page: the all-zero no-op and the return-to-page-0 command. Data bytes are the same on every page as well.

The registers held here are the page, the X column pointer (0..127) and the Y bank pointer (0..5). The configuration fields are power-down, entry direction, multiplex rate, display mode, bias, generator enable and range, and multiplication factor. A data byte produces a one-cycle write strobe. The strobe carries the address that was current when the byte arrived, and the pointer then steps in the direction that the entry bit selects. All outputs are registered, so each byte takes effect on the clock edge that samples it.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, these are all 0: page, x_addr, y_addr, entry_vert, mux_rate, disp_ctrl, bias_sel, hv_enable, hv_range, hv_mult and ram_we. power_down is 1.
- R2: On every page, command 8'h00 changes nothing. On every page, command 8'h01 sets page to 0.
- R3: On page 0, command 4'b0010 followed by {p,v,h1,h0} sets the following fields:
  - power_down to p.
  - entry_vert to v.
  - page to {h1,h0}.
- R4: On page 0, a command with bit 7 set loads x_addr from bits 6:0.
- R5: On page 0, command 5'b01000 followed by y[2:0] loads y_addr when y is 5 or less. When y is greater than 5, nothing changes. y_addr never exceeds 5.
- R6: On page 1, the following commands are decoded:
  - 6'b000001 followed by m[1:0] sets mux_rate.
  - 5'b00001 followed by {D,IM,E} sets disp_ctrl to {D,IM,E}, with bit 2 = D, bit 1 = IM and bit 0 = E.
  - 5'b00010 followed by b[2:0] sets bias_sel.
- R7: On page 2, the following commands are decoded:
  - 6'b000001 followed by {r,e} sets hv_range to r and hv_enable to e.
  - 6'b000010 followed by f[1:0] sets hv_mult.
- R8: A command byte that has no meaning on the current page leaves every register unchanged. Page 3 has only the commands of R2.
- R9: A byte with is_data high produces ram_we high for exactly the following cycle. During that cycle, ram_x and ram_y hold the address from before the write and ram_data holds the byte. The page and configuration are not changed.
- R10: With entry_vert 0, a data write increments x_addr. When x_addr is 127, it wraps to 0 and y_addr steps, with y_addr wrapping from 5 to 0.
- R11: With entry_vert 1, a data write increments y_addr. When y_addr is 5, it wraps to 0 and x_addr steps, with x_addr wrapping from 127 to 0.
- R12: While byte_valid is low, no register changes and ram_we stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | One-cycle strobe qualifying cmd_byte |
| is_data | input | 1 | 1 = display data, 0 = command |
| cmd_byte | input | 8 | Incoming byte |
| page | output | 2 | Current command page |
| x_addr | output | 7 | Column pointer |
| y_addr | output | 3 | Bank pointer |
| power_down | output | 1 | Power-down flag |
| entry_vert | output | 1 | Entry direction, 1 = bank first |
| mux_rate | output | 2 | Multiplex rate |
| disp_ctrl | output | 3 | Display mode {D,IM,E} |
| bias_sel | output | 3 | Bias system |
| hv_enable | output | 1 | Voltage generator enable |
| hv_range | output | 1 | Generator programming range |
| hv_mult | output | 2 | Voltage multiplication factor |
| ram_we | output | 1 | Display RAM write strobe |
| ram_x | output | 7 | Write column |
| ram_y | output | 3 | Write bank |
| ram_data | output | 8 | Write data |

## Verification
The write strobe and the pointer advance happen on the same edge. The strobe must carry the old address while x_addr and y_addr already hold the stepped one. The bench provokes this at the corner where the pointer is at column 127 and bank 5, in both entry directions, so that both axes wrap on the edge that issues the write. On the cycle after that write, the bench checks ram_x=127, ram_y=5 and the data byte against x_addr=0, y_addr=0.

// File: rtl/lcd_cmd_pkg.sv
// Shared types for the paged LCD command decoder.
// Assumes: one byte at most per cycle; opcode classes are exclusive.
package lcd_cmd_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_WRITE,
        OP_PAGE_DEF,
        OP_FUNC,
        OP_SET_X,
        OP_SET_Y,
        OP_MUX,
        OP_DISP,
        OP_BIAS,
        OP_HVCTL,
        OP_HVMUL
    } op_kind_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lcd_op_decode.sv
// Combinational opcode classifier. The result depends on the current page.
// Assumes: the caller qualifies the result with the byte strobe.
// Out-of-range bank values are classified as OP_NONE.
module lcd_op_decode
    import lcd_cmd_pkg::*;
#(
    parameter int Y_MAX = 5
) (
    input  logic [1:0]        page,
    input  logic              is_data,
    input  logic [BYTE_W-1:0] cmd,
    output op_kind_e          kind
);

    // Classify the byte: page-independent codes first, then the page tables.
    always_comb begin
        kind = OP_NONE;
        if (is_data) begin
            kind = OP_WRITE;
        end else if (cmd == 8'h01) begin
            kind = OP_PAGE_DEF;
        end else if (cmd != 8'h00) begin
            case (page)
                2'd0: begin
                    if (cmd[7])
                        kind = OP_SET_X;
                    else if (cmd[7:3] == 5'b01000 && int'(cmd[2:0]) <= Y_MAX)
                        kind = OP_SET_Y;
                    else if (cmd[7:4] == 4'b0010)
                        kind = OP_FUNC;
                end
                2'd1: begin
                    if (cmd[7:2] == 6'b000001)
                        kind = OP_MUX;
                    else if (cmd[7:3] == 5'b00001)
                        kind = OP_DISP;
                    else if (cmd[7:3] == 5'b00010)
                        kind = OP_BIAS;
                end
                2'd2: begin
                    if (cmd[7:2] == 6'b000001)
                        kind = OP_HVCTL;
                    else if (cmd[7:2] == 6'b000010)
                        kind = OP_HVMUL;
                end
                default: kind = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_cfg_regs.sv
// Page and configuration registers. Each register is loaded from the
// argument bits of a decoded command.
// Assumes: kind is OP_NONE whenever no valid byte is present.
module lcd_cfg_regs
    import lcd_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_kind_e   kind,
    input  logic [3:0] arg,
    output logic [1:0] page,
    output logic       power_down,
    output logic       entry_vert,
    output logic [1:0] mux_rate,
    output logic [2:0] disp_ctrl,
    output logic [2:0] bias_sel,
    output logic       hv_enable,
    output logic       hv_range,
    output logic [1:0] hv_mult
);

    // Load the field that the decoded command names; hold all others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page       <= 2'd0;
            power_down <= 1'b1;
            entry_vert <= 1'b0;
            mux_rate   <= 2'd0;
            disp_ctrl  <= 3'd0;
            bias_sel   <= 3'd0;
            hv_enable  <= 1'b0;
            hv_range   <= 1'b0;
            hv_mult    <= 2'd0;
        end else begin
            case (kind)
                OP_PAGE_DEF: page <= 2'd0;
                OP_FUNC: begin
                    power_down <= arg[3];
                    entry_vert <= arg[2];
                    page       <= arg[1:0];
                end
                OP_MUX:   mux_rate  <= arg[1:0];
                OP_DISP:  disp_ctrl <= arg[2:0];
                OP_BIAS:  bias_sel  <= arg[2:0];
                OP_HVCTL: begin
                    hv_range  <= arg[1];
                    hv_enable <= arg[0];
                end
                OP_HVMUL: hv_mult <= arg[1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lcd_addr_ptr.sv
// X/Y display-RAM pointer and write-strobe register. Direct loads come from
// commands. Data writes step the pointer in the direction set by entry_vert.
// The write port presents the address from before the step.
// Assumes: set-Y values were already range-checked by the decoder.
module lcd_addr_ptr
    import lcd_cmd_pkg::*;
#(
    parameter int X_MAX = 127,
    parameter int Y_MAX = 5,
    localparam int XW = $clog2(X_MAX + 1),
    localparam int YW = $clog2(Y_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_kind_e          kind,
    input  logic [BYTE_W-1:0] cmd,
    input  logic              entry_vert,
    output logic [XW-1:0]     x_addr,
    output logic [YW-1:0]     y_addr,
    output logic              ram_we,
    output logic [XW-1:0]     ram_x,
    output logic [YW-1:0]     ram_y,
    output logic [BYTE_W-1:0] ram_data
);

    localparam logic [XW-1:0] X_LAST = XW'(X_MAX);
    localparam logic [YW-1:0] Y_LAST = YW'(Y_MAX);

    logic          x_end, y_end;
    logic [XW-1:0] x_inc;
    logic [YW-1:0] y_inc;
    logic [XW-1:0] x_step;
    logic [YW-1:0] y_step;

    // Wrapping increments for each axis.
    always_comb begin
        x_end = (x_addr == X_LAST);
        y_end = (y_addr == Y_LAST);
        x_inc = x_end ? '0 : x_addr + 1'b1;
        y_inc = y_end ? '0 : y_addr + 1'b1;
    end

    // Post-write address: fast axis chosen by entry direction.
    always_comb begin
        if (entry_vert) begin
            y_step = y_inc;
            x_step = y_end ? x_inc : x_addr;
        end else begin
            x_step = x_inc;
            y_step = x_end ? y_inc : y_addr;
        end
    end

    // Pointer update from commands and data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_addr <= '0;
            y_addr <= '0;
        end else begin
            case (kind)
                OP_SET_X: x_addr <= cmd[XW-1:0];
                OP_SET_Y: y_addr <= cmd[YW-1:0];
                OP_WRITE: begin
                    x_addr <= x_step;
                    y_addr <= y_step;
                end
                default: ;
            endcase
        end
    end

    // One-cycle write strobe carrying the pre-step address and the byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we   <= 1'b0;
            ram_x    <= '0;
            ram_y    <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= (kind == OP_WRITE);
            if (kind == OP_WRITE) begin
                ram_x    <= x_addr;
                ram_y    <= y_addr;
                ram_data <= cmd;
            end
        end
    end

endmodule

// File: rtl/lcd_cmd_decoder.sv
// Top of the paged command decoder. It qualifies the classified opcode with
// the byte strobe and distributes it to the configuration registers and the
// address pointer.
// Assumes: the serial front end delivers whole bytes with a one-cycle strobe.
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int X_MAX = 127,
    parameter int Y_MAX = 5,
    localparam int XW = $clog2(X_MAX + 1),
    localparam int YW = $clog2(Y_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              is_data,
    input  logic [BYTE_W-1:0] cmd_byte,
    output logic [1:0]        page,
    output logic [XW-1:0]     x_addr,
    output logic [YW-1:0]     y_addr,
    output logic              power_down,
    output logic              entry_vert,
    output logic [1:0]        mux_rate,
    output logic [2:0]        disp_ctrl,
    output logic [2:0]        bias_sel,
    output logic              hv_enable,
    output logic              hv_range,
    output logic [1:0]        hv_mult,
    output logic              ram_we,
    output logic [XW-1:0]     ram_x,
    output logic [YW-1:0]     ram_y,
    output logic [BYTE_W-1:0] ram_data
);

    op_kind_e kind_raw;
    op_kind_e kind;

    lcd_op_decode #(.Y_MAX(Y_MAX)) u_dec (
        .page    (page),
        .is_data (is_data),
        .cmd     (cmd_byte),
        .kind    (kind_raw)
    );

    // Only a strobed byte may act.
    always_comb kind = byte_valid ? kind_raw : OP_NONE;

    lcd_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .arg        (cmd_byte[3:0]),
        .page       (page),
        .power_down (power_down),
        .entry_vert (entry_vert),
        .mux_rate   (mux_rate),
        .disp_ctrl  (disp_ctrl),
        .bias_sel   (bias_sel),
        .hv_enable  (hv_enable),
        .hv_range   (hv_range),
        .hv_mult    (hv_mult)
    );

    lcd_addr_ptr #(.X_MAX(X_MAX), .Y_MAX(Y_MAX)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .cmd        (cmd_byte),
        .entry_vert (entry_vert),
        .x_addr     (x_addr),
        .y_addr     (y_addr),
        .ram_we     (ram_we),
        .ram_x      (ram_x),
        .ram_y      (ram_y),
        .ram_data   (ram_data)
    );

endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
// Property checker for lcd_cmd_decoder, attached by bind.
// Assumes: synchronous active-low reset; all checks are disabled in reset.
module lcd_cmd_decoder_chk #(
    parameter int X_MAX = 127,
    parameter int Y_MAX = 5,
    localparam int XW = $clog2(X_MAX + 1),
    localparam int YW = $clog2(Y_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_valid,
    input logic          is_data,
    input logic [7:0]    cmd_byte,
    input logic [1:0]    page,
    input logic [XW-1:0] x_addr,
    input logic [YW-1:0] y_addr,
    input logic          entry_vert,
    input logic          ram_we,
    input logic [XW-1:0] ram_x,
    input logic [YW-1:0] ram_y
);

    // R9
    ram_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(byte_valid && is_data));

    // R9
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && is_data) |=>
            (ram_we && ram_x == $past(x_addr) && ram_y == $past(y_addr)));

    // R5
    y_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(y_addr) <= Y_MAX);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=>
            (!ram_we && $stable(x_addr) && $stable(y_addr) && $stable(page)));

    // R2
    page_def_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !is_data && cmd_byte == 8'h01) |=> (page == 2'd0));

    // R10
    ent0_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && is_data && !entry_vert && int'(x_addr) != X_MAX) |=>
            (x_addr == XW'($past(x_addr) + 1'b1) && $stable(y_addr)));

endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(.X_MAX(X_MAX), .Y_MAX(Y_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .is_data    (is_data),
    .cmd_byte   (cmd_byte),
    .page       (page),
    .x_addr     (x_addr),
    .y_addr     (y_addr),
    .entry_vert (entry_vert),
    .ram_we     (ram_we),
    .ram_x      (ram_x),
    .ram_y      (ram_y)
);

// File: tb/tb_lcd_cmd_decoder.sv
`timescale 1ns/1ps
module tb_lcd_cmd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic       is_data = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [1:0] page;
    logic [6:0] x_addr;
    logic [2:0] y_addr;
    logic       power_down, entry_vert;
    logic [1:0] mux_rate;
    logic [2:0] disp_ctrl, bias_sel;
    logic       hv_enable, hv_range;
    logic [1:0] hv_mult;
    logic       ram_we;
    logic [6:0] ram_x;
    logic [2:0] ram_y;
    logic [7:0] ram_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lcd_cmd_decoder dut (.*);

    localparam int F_PAGE = 0, F_X = 1, F_Y = 2, F_PD = 3, F_ENT = 4,
                   F_MUX = 5, F_DISP = 6, F_BIAS = 7, F_HVCTL = 8,
                   F_HVMUL = 9, F_WE = 10;

    typedef struct packed {
        logic       rs;
        logic [7:0] b;
        logic [3:0] fld;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 4'(F_PD),    8'd1,   4'd2},  // R2 nop on page 0
        '{1'b0, 8'h85, 4'(F_X),     8'd5,   4'd4},  // R4
        '{1'b0, 8'h43, 4'(F_Y),     8'd3,   4'd5},  // R5 legal bank
        '{1'b0, 8'h46, 4'(F_Y),     8'd3,   4'd5},  // R5 bank 6 ignored
        '{1'b1, 8'hA5, 4'(F_WE),    8'd1,   4'd9},  // R9
        '{1'b1, 8'h3C, 4'(F_X),     8'd7,   4'd10}, // R10
        '{1'b0, 8'h21, 4'(F_PAGE),  8'd1,   4'd3},  // R3
        '{1'b0, 8'h06, 4'(F_MUX),   8'd2,   4'd6},  // R6
        '{1'b0, 8'h0D, 4'(F_DISP),  8'd5,   4'd6},  // R6 D=1 IM=0 E=1
        '{1'b0, 8'h13, 4'(F_BIAS),  8'd3,   4'd6},  // R6
        '{1'b0, 8'h85, 4'(F_X),     8'd7,   4'd8},  // R8 set-X on page 1
        '{1'b0, 8'h47, 4'(F_Y),     8'd3,   4'd8},  // R8
        '{1'b0, 8'h01, 4'(F_PAGE),  8'd0,   4'd2},  // R2
        '{1'b0, 8'h26, 4'(F_PAGE),  8'd2,   4'd3},  // R3 page 2, entry 1
        '{1'b0, 8'h07, 4'(F_HVCTL), 8'd3,   4'd7},  // R7
        '{1'b0, 8'h0A, 4'(F_HVMUL), 8'd2,   4'd7},  // R7
        '{1'b0, 8'h0F, 4'(F_HVMUL), 8'd2,   4'd8},  // R8 undefined on page 2
        '{1'b0, 8'h05, 4'(F_MUX),   8'd2,   4'd7},  // R7 not a mux command here
        '{1'b0, 8'h01, 4'(F_PAGE),  8'd0,   4'd2},  // R2
        '{1'b0, 8'h23, 4'(F_PAGE),  8'd3,   4'd3},  // R3 page 3, entry 0
        '{1'b0, 8'h85, 4'(F_X),     8'd7,   4'd8},  // R8 page 3 is empty
        '{1'b0, 8'h00, 4'(F_PAGE),  8'd3,   4'd2},  // R2 nop on page 3
        '{1'b0, 8'h01, 4'(F_PAGE),  8'd0,   4'd2}   // R2
    };

    function automatic logic [7:0] field(int f);
        case (f)
            F_PAGE:  return {6'd0, page};
            F_X:     return {1'b0, x_addr};
            F_Y:     return {5'd0, y_addr};
            F_PD:    return {7'd0, power_down};
            F_ENT:   return {7'd0, entry_vert};
            F_MUX:   return {6'd0, mux_rate};
            F_DISP:  return {5'd0, disp_ctrl};
            F_BIAS:  return {5'd0, bias_sel};
            F_HVCTL: return {6'd0, hv_range, hv_enable};
            F_HVMUL: return {6'd0, hv_mult};
            default: return {7'd0, ram_we};
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one byte for one cycle. Returns at the next falling edge.
    task automatic send(logic rs, logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        is_data = rs;
        cmd_byte = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic check_reset_state(string tag);
        check(tag, field(F_PAGE), 8'd0);
        check(tag, field(F_X), 8'd0);
        check(tag, field(F_Y), 8'd0);
        check(tag, field(F_PD), 8'd1);
        check(tag, field(F_ENT), 8'd0);
        check(tag, field(F_MUX), 8'd0);
        check(tag, field(F_DISP), 8'd0);
        check(tag, field(F_BIAS), 8'd0);
        check(tag, field(F_HVCTL), 8'd0);
        check(tag, field(F_HVMUL), 8'd0);
        check(tag, field(F_WE), 8'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            send(VEC[i].rs, VEC[i].b);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), field(int'(VEC[i].fld)), VEC[i].exp);
        end

        // R10 and R9: both axes wrap on the edge that issues the write.
        send(1'b0, 8'hFF);
        send(1'b0, 8'h45);
        send(1'b1, 8'h11);
        check("R9 we", field(F_WE), 8'd1);
        check("R9 ram_x", {1'b0, ram_x}, 8'd127);
        check("R9 ram_y", {5'd0, ram_y}, 8'd5);
        check("R9 ram_data", ram_data, 8'h11);
        check("R9 page kept", field(F_PAGE), 8'd0);
        check("R10 x wrap", field(F_X), 8'd0);
        check("R10 y wrap", field(F_Y), 8'd0);

        // R11: bank-first stepping.
        send(1'b0, 8'h24);
        check("R3 entry", field(F_ENT), 8'd1);
        send(1'b0, 8'h8A);
        send(1'b0, 8'h44);
        send(1'b1, 8'h22);
        check("R11 y step", field(F_Y), 8'd5);
        check("R11 x hold", field(F_X), 8'd10);
        send(1'b1, 8'h33);
        check("R11 y wrap", field(F_Y), 8'd0);
        check("R11 x step", field(F_X), 8'd11);
        check("R11 ram_y", {5'd0, ram_y}, 8'd5);
        send(1'b0, 8'hFF);
        send(1'b0, 8'h45);
        send(1'b1, 8'h44);
        check("R11 x wrap", field(F_X), 8'd0);
        check("R11 y wrap2", field(F_Y), 8'd0);
        check("R11 ram_x", {1'b0, ram_x}, 8'd127);

        // R12: strobe low, byte present.
        send(1'b0, 8'h85);
        @(negedge clk);
        is_data = 1'b1;
        cmd_byte = 8'h9C;
        @(negedge clk);
        @(negedge clk);
        check("R12 x", field(F_X), 8'd5);
        check("R12 y", field(F_Y), 8'd0);
        check("R12 we", field(F_WE), 8'd0);
        is_data = 1'b0;

        // R1: reset in the middle of a run.
        send(1'b0, 8'h2A);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1 mid");
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule